// File: doc/BRIEF.md
# Panel Register Write Sequencer over SPI

This block drives the serial control port of a display panel. It has a small set of fixed command sequences: power-up, resume, suspend and shutdown. Each sequence is a short list of register writes. A register write takes two separate chip-select frames of three bytes each. The first frame names the target register. The second frame carries the 16-bit value. The serial link runs in SPI mode 0, most significant bit first. The serial clock comes from the system clock through a parameterised divider.

The panel's orientation and colour-order settings arrive as four mode inputs. They are sampled when a sequence starts. They are merged into a fixed default word to form the value written to the output-setup register. A start pulse launches a sequence. `busy` stays high for the whole sequence. `done` pulses once after the final frame has ended. Anything received from the panel is ignored.

Top module: `panel_cmd_seq`

## Requirements
- R1: An index frame is 24 bits: byte 0x74, then 0x00, then the 8-bit register number.
- R2: A data frame is 24 bits: byte 0x76, then the high byte of the value, then the low byte. Every register write sends its index frame first and its data frame second.
- R3: `cs_n` is low for exactly 24 rising edges of `sclk` per frame. It returns high between any two frames, including the two frames of one write. It is low only while `busy` is high.
- R4: The serial link uses mode 0. `sclk` is low whenever `cs_n` changes. `mosi` is sampled on the rising edge and changes only on a falling edge while `cs_n` is low. Bytes are sent most significant bit first.
- R5: The power-up sequence (`start_on`) has two writes. It first writes register 0x11 with 0x0000, then register 0x01 with the setup value.
- R6: The resume sequence (`start_resume`) has two writes. It first writes register 0x01 with the setup value, then register 0x11 with 0x0000.
- R7: The suspend sequence (`start_suspend`) and the shutdown sequence (`start_shutdown`) are identical. Each makes a single write of 0x0001 to register 0x11.
- R8: The setup value starts from 0x00EF, which is 0x2AEF with bits 14, 13, 11 and 9 cleared. Bits from the mode input are then placed as follows: mode[0] (left-right mirror) goes to bit 14, mode[1] (top-bottom mirror) to bit 9, mode[2] (blue-first order) to bit 11, and mode[3] (reverse) to bit 13.
- R9: A start request that arrives while `busy` is high is ignored. The mode inputs are captured at start, so changes during a sequence have no effect on it.
- R10: `done` is high for exactly one cycle, in the first cycle with `busy` low after the final frame. When several starts are high in one idle cycle, only one runs, in this priority: power-up, then resume, then suspend, then shutdown.
- R11: Consecutive rising edges of `sclk` within a frame are 2*HALF_DIV system clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_on | input | 1 | Launch power-up sequence |
| start_resume | input | 1 | Launch resume sequence |
| start_suspend | input | 1 | Launch suspend sequence |
| start_shutdown | input | 1 | Launch shutdown sequence |
| mode | input | 4 | Orientation and colour-order bits |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the panel |
| cs_n | output | 1 | Active-low frame select |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
Suppose the slot counter, the frame index or the stored setup value goes wrong. The port monitor would then see a frame of the wrong length, a wrong byte, or frames in the wrong order. Each of these shows up at the end of the affected frame, within about 50 half-periods of `sclk`. A fault in the sequence selection or the frame count would instead show as a wrong number of frames before `done`. A late or missing `done` pulse is caught the cycle it should have appeared. A phase error on the serial clock is flagged at the next `cs_n` edge or `mosi` transition that breaks mode 0.

// File: rtl/panel_cmd_seq.sv
module panel_cmd_seq #(
  parameter int          HALF_DIV    = 2,
  parameter int          GAP_SLOTS   = 2,
  parameter logic [15:0] OUT_DEFAULT = 16'h2AEF,
  parameter int          LR_POS      = 14,
  parameter int          TB_POS      = 9,
  parameter int          BGR_POS     = 11,
  parameter int          REV_POS     = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_on,
  input  logic       start_resume,
  input  logic       start_suspend,
  input  logic       start_shutdown,
  input  logic [3:0] mode,
  output logic       sclk,
  output logic       mosi,
  output logic       cs_n,
  output logic       busy,
  output logic       done
);

  localparam int          DIVW      = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int          CLK_SLOTS = 48;
  localparam int          LAST_SLOT = CLK_SLOTS + GAP_SLOTS;
  localparam int          SLOTW     = $clog2(LAST_SLOT + 1);
  localparam logic [15:0] MODE_MASK = (16'd1 << LR_POS) | (16'd1 << TB_POS) |
                                      (16'd1 << BGR_POS) | (16'd1 << REV_POS);
  localparam logic [7:0]  IDX_PFX   = 8'h74;
  localparam logic [7:0]  DAT_PFX   = 8'h76;
  localparam logic [7:0]  REG_PWR   = 8'h11;
  localparam logic [7:0]  REG_SETUP = 8'h01;

  typedef enum logic [1:0] {SQ_ON, SQ_RESUME, SQ_OFF} seq_t;

  seq_t             seq_q;
  logic             active_q, done_q, sclk_q;
  logic [1:0]       fidx_q;
  logic [SLOTW-1:0] slot_q;
  logic [DIVW-1:0]  div_q;
  logic [23:0]      sh_q;
  logic [15:0]      ctl_q;

  function automatic logic [15:0] setup_word(input logic [3:0] m);
    logic [15:0] v;
    v = OUT_DEFAULT & ~MODE_MASK;
    v[LR_POS]  = m[0];
    v[TB_POS]  = m[1];
    v[BGR_POS] = m[2];
    v[REV_POS] = m[3];
    return v;
  endfunction

  function automatic logic [23:0] frame_word(input seq_t s, input logic [1:0] f,
                                             input logic [15:0] ctl);
    logic [7:0]  r;
    logic [15:0] v;
    logic        pwr_first;
    pwr_first = (s != SQ_RESUME);
    if (s == SQ_OFF) begin
      r = REG_PWR;
      v = 16'h0001;
    end else if (f[1] ^ pwr_first) begin
      r = REG_PWR;
      v = 16'h0000;
    end else begin
      r = REG_SETUP;
      v = ctl;
    end
    return f[0] ? {DAT_PFX, v} : {IDX_PFX, 8'h00, r};
  endfunction

  wire       any_start = start_on | start_resume | start_suspend | start_shutdown;
  wire seq_t next_seq  = start_on ? SQ_ON : (start_resume ? SQ_RESUME : SQ_OFF);
  wire [15:0] next_ctl = setup_word(mode);
  wire [1:0] last_fidx = (seq_q == SQ_OFF) ? 2'd1 : 2'd3;
  wire       tick      = (div_q == DIVW'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      sclk_q   <= 1'b0;
      seq_q    <= SQ_ON;
      fidx_q   <= '0;
      slot_q   <= '0;
      div_q    <= '0;
      sh_q     <= '0;
      ctl_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        div_q <= '0;
        if (any_start) begin
          active_q <= 1'b1;
          seq_q    <= next_seq;
          ctl_q    <= next_ctl;
          fidx_q   <= '0;
          slot_q   <= '0;
          sh_q     <= frame_word(next_seq, 2'd0, next_ctl);
        end
      end else begin
        div_q <= tick ? '0 : div_q + 1'b1;
        if (tick) begin
          if (slot_q != SLOTW'(LAST_SLOT)) begin
            slot_q <= slot_q + 1'b1;
            sclk_q <= (slot_q < SLOTW'(CLK_SLOTS)) && !slot_q[0];
            if (slot_q[0] && slot_q < SLOTW'(CLK_SLOTS - 1))
              sh_q <= {sh_q[22:0], 1'b0};
          end else if (fidx_q != last_fidx) begin
            fidx_q <= fidx_q + 1'b1;
            slot_q <= '0;
            sh_q   <= frame_word(seq_q, fidx_q + 1'b1, ctl_q);
          end else begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end
        end
      end
    end
  end

  assign cs_n = !active_q || (slot_q > SLOTW'(CLK_SLOTS));
  assign sclk = sclk_q;
  assign mosi = !cs_n && sh_q[23];
  assign busy = active_q;
  assign done = done_q;

endmodule

module panel_cmd_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start_on,
  input logic start_resume,
  input logic start_suspend,
  input logic start_shutdown,
  input logic sclk,
  input logic mosi,
  input logic cs_n,
  input logic busy,
  input logic done
);
  p_cs_in_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);
  p_sclk_low_cs_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cs_n) |-> !sclk);
  p_mosi_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && !$stable(mosi)) |-> $fell(sclk));
  p_busy_from_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_on | start_resume | start_suspend | start_shutdown));
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_ends_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

bind panel_cmd_seq panel_cmd_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start_on(start_on), .start_resume(start_resume),
  .start_suspend(start_suspend), .start_shutdown(start_shutdown),
  .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .busy(busy), .done(done)
);

// File: tb/panel_cmd_seq_tb_top.sv
module panel_cmd_seq_tb_top;
  localparam int HALF_DIV = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic s_on = 0, s_res = 0, s_sus = 0, s_shd = 0;
  logic [3:0] mode = '0;
  logic sclk, mosi, cs_n, busy, done;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  panel_cmd_seq #(.HALF_DIV(HALF_DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_on(s_on), .start_resume(s_res),
    .start_suspend(s_sus), .start_shutdown(s_shd), .mode(mode),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .busy(busy), .done(done));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [23:0] got_f [0:15];
  int          got_n = 0;
  logic [23:0] sh;
  int          bc, cyc = 0, last_rise;
  logic        prev_cs = 1'b1, prev_sclk = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prev_cs && !cs_n) begin
        sh = '0; bc = 0; last_rise = -1;
        chk(sclk == 0, "R4 sclk low at cs fall", sclk, 0);
      end
      if (!cs_n && !prev_sclk && sclk) begin
        sh = {sh[22:0], mosi};
        if (bc == 1) chk(cyc - last_rise == 2 * HALF_DIV, "R11 sclk period",
                         cyc - last_rise, 2 * HALF_DIV);
        bc++;
        last_rise = cyc;
      end
      if (!prev_cs && cs_n) begin
        chk(bc == 24, "R3 bits per frame", bc, 24);
        chk(sclk == 0, "R4 sclk low at cs rise", sclk, 0);
        if (got_n < 16) got_f[got_n] = sh;
        got_n++;
      end
    end
    prev_cs = cs_n;
    prev_sclk = sclk;
  end

  function automatic logic [15:0] exp_ctl(input logic [3:0] m);
    logic [15:0] v = 16'h00EF;
    v[14] = m[0]; v[9] = m[1]; v[11] = m[2]; v[13] = m[3];
    return v;
  endfunction

  function automatic logic [23:0] exp_frame(input int kind, input int f,
                                            input logic [3:0] m);
    logic [7:0] r; logic [15:0] v;
    int w = f / 2;
    if (kind >= 2) begin r = 8'h11; v = 16'h0001; end
    else if ((kind == 0) == (w == 0)) begin r = 8'h11; v = 16'h0000; end
    else begin r = 8'h01; v = exp_ctl(m); end
    return (f % 2) ? {8'h76, v} : {8'h74, 8'h00, r};
  endfunction

  task automatic pulse(input logic [3:0] which);
    @(negedge clk);
    {s_shd, s_sus, s_res, s_on} = which;
    @(negedge clk);
    {s_shd, s_sus, s_res, s_on} = '0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk(done == 1, {tag, " R10 done seen"}, done, 1);
    chk(busy == 0, {tag, " R10 busy low with done"}, busy, 0);
    @(negedge clk);
    chk(done == 0, {tag, " R10 done one cycle"}, done, 0);
  endtask

  task automatic compare(input int kind, input logic [3:0] m, input string tag);
    int nexp = (kind >= 2) ? 2 : 4;
    chk(got_n == nexp, {tag, " frame count R5 R6 R7"}, got_n, nexp);
    for (int i = 0; i < nexp && i < got_n; i++)
      chk(got_f[i] == exp_frame(kind, i, m), {tag, " frame R1 R2 R8"},
          got_f[i], exp_frame(kind, i, m));
  endtask

  task automatic run(input int kind, input logic [3:0] m, input string tag);
    got_n = 0;
    mode = m;
    pulse(4'b0001 << kind);
    wait_done(tag);
    compare(kind, m, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    chk(cs_n == 1 && sclk == 0 && busy == 0 && done == 0, "reset idle R3 R4",
        {cs_n, sclk, busy, done}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);

    run(0, 4'h0, "R5 on");
    run(0, 4'hF, "R5 R8 on all bits");
    run(1, 4'h5, "R6 resume");
    run(2, 4'hA, "R7 suspend");
    run(3, 4'h3, "R7 shutdown");

    got_n = 0; mode = 4'h6;
    pulse(4'b1001);
    wait_done("R10 prio on");
    compare(0, 4'h6, "R10 prio on");
    got_n = 0; mode = 4'h9;
    pulse(4'b0110);
    wait_done("R10 prio resume");
    compare(1, 4'h9, "R10 prio resume");

    got_n = 0; mode = 4'h2;
    pulse(4'b0001);
    repeat (150) @(negedge clk);
    mode = 4'hD;
    pulse(4'b1000);
    pulse(4'b0010);
    wait_done("R9 busy ignore");
    compare(0, 4'h2, "R9 busy ignore");
    repeat (300) @(negedge clk);
    chk(got_n == 4 && cs_n == 1 && busy == 0, "R9 no queued start",
        got_n, 4);

    for (int i = 0; i < 20; i++) begin
      int k = $urandom_range(3, 0);
      logic [3:0] m = 4'($urandom);
      run(k, m, "random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule